// File: doc/BRIEF.md
# Transmit Status and Completion Tracker

This block keeps the status of a serial transmitter that has a 16-entry transmit queue. It holds the queued characters and hands them to the serializer through a valid/ready pop port. It watches the serializer's per-character done pulse and raises four flags: transmit-complete, room-available, queue-empty and a threshold flag that reports free space.

The complete flag depends on a programmed character count. A count of zero gives the usual rule: complete rises when a character finishes shifting while the queue is empty. With a nonzero count, complete rises once that many characters have finished since the last clear or count load. This can happen while the queue still holds data. If the queue drains first, complete stays low until more data is written and sent.

A flush request discards the queued data one entry per cycle. The room-available and empty flags stay low during the flush and rise together when the queue is empty.

Top module: `tx_status_ctrl`

## Requirements
- R1: After reset, tc_o and pop_valid_o are low, and not_full_o, empty_o and thr_o are high.
- R2: With a count of 0, tc_o rises one cycle after a shift_done_i pulse that arrives while the queue holds no entry. A pulse that arrives while the queue holds data leaves tc_o low.
- R3: With a nonzero count N, tc_o rises one cycle after the N-th shift_done_i pulse counted since the last counter reset. This happens even while the queue still holds data.
- R4: With a nonzero count, if the queue drains before N characters are done, tc_o stays low. Host writes made while tc_o is low keep the partial count, and tc_o rises once the added characters bring the count to N.
- R5: A tc_clr_i pulse, or any host write (wr_en_i), makes tc_o low in the next cycle. The clear takes priority over a same-cycle set.
- R6: The sent-character counter returns to zero on tc_clr_i, on cnt_load_i, or on a host write while tc_o is high. A shift_done_i in that same cycle is not counted.
- R7: not_full_o is low exactly while the queue holds 16 entries or a flush is in progress.
- R8: A host write while the queue is full, or while a flush is in progress, is dropped and leaves the occupancy unchanged.
- R9: A flush_i pulse while entries are present starts a flush one cycle later. The flush removes one entry per cycle and holds pop_valid_o, not_full_o and empty_o low. not_full_o and empty_o rise in the same cycle as the last entry leaves. A flush of an empty queue has no visible effect.
- R10: thr_o is high when the number of free entries is at least the level selected by thr_code_i. The levels are: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12, 4 gives 14, and 5 to 7 give 16.
- R11: Entries leave in write order. pop_valid_o is high while the queue holds data and no flush is in progress. An entry is removed in a cycle where pop_valid_o and pop_ready_i are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host data write strobe |
| wr_data_i | input | 8 | Host write data |
| pop_ready_i | input | 1 | Serializer takes the head entry |
| pop_valid_o | output | 1 | Head entry available |
| pop_data_o | output | 8 | Head entry data |
| shift_done_i | input | 1 | One character finished shifting out |
| flush_i | input | 1 | Flush request pulse |
| cnt_load_i | input | 1 | Load the character count |
| cnt_val_i | input | 8 | Character count, 0 = unused |
| thr_code_i | input | 3 | Free-space threshold code |
| tc_clr_i | input | 1 | Write-1 clear of transmit-complete |
| tc_o | output | 1 | Transmit complete |
| not_full_o | output | 1 | Queue can accept a write |
| empty_o | output | 1 | Queue empty |
| thr_o | output | 1 | Free space at or above threshold |

## Verification
The assertions check on every cycle that:
- the occupancy never passes the depth, and a write to a full queue leaves it full;
- pop_valid_o, not_full_o and empty_o stay low during a flush, and not_full_o and empty_o rise together when it ends;
- a clear or a host write always leaves tc_o low;
- with a count of zero, a done pulse while data is queued never sets tc_o.

Only the directed scenarios can show the effects that depend on sequences:
- completion after exactly N done pulses, and the partial count surviving a drain;
- counter resets by reload;
- the exact cycle in which a flush ends;
- first-in first-out data order;
- each threshold level.

// File: rtl/tx_status_pkg.sv
package tx_status_pkg;
  // free-entry level selected by a threshold code, for a given depth
  function automatic int unsigned thr_slots(logic [2:0] code, int unsigned depth);
    case (code)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth;
    endcase
  endfunction
endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_ready_i,
  output logic              pop_valid_o,
  output logic [DATA_W-1:0] pop_data_o,
  input  logic              flush_i,
  output logic [OCC_W-1:0]  occ_o,
  output logic              flushing_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [OCC_W-1:0]  occ_q, occ_d;
  logic              flushing_q, flushing_d;
  logic              push, pop_fire, rd_adv;

  assign pop_valid_o = (occ_q != '0) && !flushing_q;
  assign pop_data_o  = mem_q[rd_ptr_q];
  assign pop_fire    = pop_valid_o && pop_ready_i;
  assign push        = wr_en_i && (occ_q != OCC_W'(DEPTH)) && !flushing_q;
  assign rd_adv      = pop_fire || flushing_q;  // flush drains one entry a cycle
  assign occ_d       = occ_q + OCC_W'(push) - OCC_W'(rd_adv);

  always_comb begin
    if (flushing_q) flushing_d = (occ_d != '0);
    else            flushing_d = flush_i && (occ_d != '0);
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      occ_q      <= '0;
      flushing_q <= 1'b0;
    end else begin
      if (push)   wr_ptr_q <= wr_ptr_q + 1'b1;
      if (rd_adv) rd_ptr_q <= rd_ptr_q + 1'b1;
      occ_q      <= occ_d;
      flushing_q <= flushing_d;
    end
  end

  assign occ_o      = occ_q;
  assign flushing_o = flushing_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OCC_W'(DEPTH)); // R8
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == OCC_W'(DEPTH) && wr_en_i && !pop_ready_i && !flushing_q) |=> occ_q == OCC_W'(DEPTH)); // R8
  AST_FLUSH_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flushing_q |-> !pop_valid_o); // R9
endmodule

// File: rtl/tx_done_track.sv
module tx_done_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             shift_done_i,
  input  logic             fifo_empty_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             tc_clr_i,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q, sent_q;
  logic [CNT_W:0]   sent_inc;
  logic             tc_q, clr, cnt_rst, reach;

  assign clr      = tc_clr_i || wr_en_i;
  assign cnt_rst  = tc_clr_i || cnt_load_i || (wr_en_i && tc_q);
  assign sent_inc = {1'b0, sent_q} + 1'b1;
  assign reach    = (cnt_q == '0) ? fifo_empty_i : (sent_inc >= {1'b0, cnt_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sent_q <= '0;
      tc_q   <= 1'b0;
    end else begin
      if (cnt_load_i) cnt_q <= cnt_val_i;
      if (cnt_rst)                           sent_q <= '0;
      else if (shift_done_i && sent_q != '1) sent_q <= sent_inc[CNT_W-1:0];
      if (clr)                        tc_q <= 1'b0;
      else if (shift_done_i && reach) tc_q <= 1'b1;
    end
  end

  assign tc_o = tc_q;

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !tc_o); // R5
  AST_ZERO_CNT_NEEDS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !fifo_empty_i && !tc_q && !cnt_load_i) |=> !tc_o); // R2
endmodule

// File: rtl/tx_level_flags.sv
module tx_level_flags #(
  parameter int DEPTH  = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OCC_W-1:0] occ_i,
  input  logic             flushing_i,
  input  logic [2:0]       thr_code_i,
  output logic             not_full_o,
  output logic             empty_o,
  output logic             thr_o
);
  import tx_status_pkg::*;
  logic [OCC_W-1:0] free_slots, level;

  assign free_slots = OCC_W'(DEPTH) - occ_i;
  assign level      = OCC_W'(thr_slots(thr_code_i, DEPTH));
  assign not_full_o = (occ_i != OCC_W'(DEPTH)) && !flushing_i;
  assign empty_o    = (occ_i == '0) && !flushing_i;
  assign thr_o      = free_slots >= level;

  AST_FLUSH_FLAGS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flushing_i |-> (!not_full_o && !empty_o)); // R9
  AST_FLAGS_RISE_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flushing_i) |-> (not_full_o && empty_o)); // R9
endmodule

// File: rtl/tx_status_ctrl.sv
module tx_status_ctrl #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_ready_i,
  output logic              pop_valid_o,
  output logic [DATA_W-1:0] pop_data_o,
  input  logic              shift_done_i,
  input  logic              flush_i,
  input  logic              cnt_load_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic [2:0]        thr_code_i,
  input  logic              tc_clr_i,
  output logic              tc_o,
  output logic              not_full_o,
  output logic              empty_o,
  output logic              thr_o
);
  logic [OCC_W-1:0] occ;
  logic             flushing;

  tx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .pop_ready_i, .pop_valid_o, .pop_data_o,
    .flush_i, .occ_o(occ), .flushing_o(flushing)
  );

  tx_done_track #(.CNT_W(CNT_W)) i_done (
    .clk_i, .rst_ni, .wr_en_i, .shift_done_i, .fifo_empty_i(occ == '0),
    .cnt_load_i, .cnt_val_i, .tc_clr_i, .tc_o
  );

  tx_level_flags #(.DEPTH(DEPTH)) i_flags (
    .clk_i, .rst_ni, .occ_i(occ), .flushing_i(flushing), .thr_code_i,
    .not_full_o, .empty_o, .thr_o
  );
endmodule

// File: tb/test_tx_status_ctrl.sv
`timescale 1ns/1ps
module test_tx_status_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, pop_ready = 0, shift_done = 0, flush = 0, cnt_load = 0, tc_clr = 0;
  logic [7:0] wr_data = '0, cnt_val = '0, pop_data;
  logic [2:0] thr_code = '0;
  logic pop_valid, tc, not_full, empty, thr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_status_ctrl i_tx_status_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .pop_ready_i(pop_ready), .pop_valid_o(pop_valid), .pop_data_o(pop_data),
    .shift_done_i(shift_done), .flush_i(flush), .cnt_load_i(cnt_load),
    .cnt_val_i(cnt_val), .thr_code_i(thr_code), .tc_clr_i(tc_clr), .tc_o(tc),
    .not_full_o(not_full), .empty_o(empty), .thr_o(thr)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic shift();
    @(negedge clk); shift_done = 1;
    @(negedge clk); shift_done = 0;
  endtask
  task automatic clr();
    @(negedge clk); tc_clr = 1;
    @(negedge clk); tc_clr = 0;
  endtask
  task automatic load(logic [7:0] n);
    @(negedge clk); cnt_load = 1; cnt_val = n;
    @(negedge clk); cnt_load = 0;
  endtask
  task automatic pop(string req, logic [7:0] exp);
    @(negedge clk);
    chk(req, "pop_valid", {7'd0, pop_valid}, 8'd1);
    chk(req, "pop_data", pop_data, exp);
    pop_ready = 1;
    @(negedge clk); pop_ready = 0;
  endtask

  task automatic t_reset();
    chk("R1", "tc", {7'd0, tc}, 0);
    chk("R1", "pop_valid", {7'd0, pop_valid}, 0);
    chk("R1", "not_full", {7'd0, not_full}, 1);
    chk("R1", "empty", {7'd0, empty}, 1);
    chk("R1", "thr", {7'd0, thr}, 1);
  endtask

  task automatic t_count_zero();
    load(0);
    wr(8'h11); wr(8'h22);
    pop("R11", 8'h11);
    shift();
    chk("R2", "tc with data queued", {7'd0, tc}, 0);
    pop("R11", 8'h22);
    shift();
    chk("R2", "tc after empty done", {7'd0, tc}, 1);
  endtask

  task automatic t_clear();
    wr(8'h33);
    chk("R5", "tc after host write", {7'd0, tc}, 0);
    pop("R11", 8'h33);
    shift();
    chk("R2", "tc set again", {7'd0, tc}, 1);
    clr();
    chk("R5", "tc after clear", {7'd0, tc}, 0);
    @(negedge clk); shift_done = 1; tc_clr = 1;
    @(negedge clk); shift_done = 0; tc_clr = 0;
    chk("R5", "clear beats set", {7'd0, tc}, 0);
    load(2); shift();
    chk("R6", "one of two", {7'd0, tc}, 0);
    load(2); shift();
    chk("R6", "reload restarts count", {7'd0, tc}, 0);
    shift();
    chk("R6", "two after reload", {7'd0, tc}, 1);
    clr();
  endtask

  task automatic t_count_n();
    load(2);
    wr(8'h41); wr(8'h42); wr(8'h43);
    shift();
    chk("R3", "tc after 1 of 2", {7'd0, tc}, 0);
    shift();
    chk("R3", "tc after 2 of 2", {7'd0, tc}, 1);
    chk("R3", "queue still holds data", {7'd0, empty}, 0);
    pop("R11", 8'h41); pop("R11", 8'h42); pop("R11", 8'h43);
    clr();
  endtask

  task automatic t_count_short();
    load(3);
    wr(8'h51); wr(8'h52);
    pop("R11", 8'h51); shift();
    pop("R11", 8'h52); shift();
    chk("R4", "empty after drain", {7'd0, empty}, 1);
    chk("R4", "tc low before count", {7'd0, tc}, 0);
    wr(8'h53);
    pop("R11", 8'h53); shift();
    chk("R4", "tc after third char", {7'd0, tc}, 1);
    clr(); load(0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 15; i++) wr(8'(i));
    chk("R7", "not_full at 15", {7'd0, not_full}, 1);
    thr_code = 3'd0; #0.1;
    chk("R10", "thr code0 one free", {7'd0, thr}, 0);
    wr(8'd15);
    chk("R7", "not_full at 16", {7'd0, not_full}, 0);
    wr(8'hEE);
    chk("R8", "still full after dropped write", {7'd0, not_full}, 0);
    for (int i = 0; i < 4; i++) pop("R11", 8'(i));
    thr_code = 3'd1; #0.1;
    chk("R10", "code1 four free", {7'd0, thr}, 1);
    thr_code = 3'd2; #0.1;
    chk("R10", "code2 four free", {7'd0, thr}, 0);
    for (int i = 4; i < 16; i++) pop("R8", 8'(i));
    chk("R8", "empty after 16 pops", {7'd0, empty}, 1);
    thr_code = 3'd7; #0.1;
    chk("R10", "code7 all free", {7'd0, thr}, 1);
  endtask

  task automatic t_flush();
    wr(8'h61); wr(8'h62); wr(8'h63);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    chk("R9", "not_full in flush", {7'd0, not_full}, 0);
    chk("R9", "empty in flush", {7'd0, empty}, 0);
    chk("R9", "pop_valid in flush", {7'd0, pop_valid}, 0);
    wr_en = 1; wr_data = 8'h77;
    @(negedge clk); wr_en = 0;
    chk("R8", "write in flush dropped", {7'd0, empty}, 0);
    @(negedge clk);
    chk("R9", "empty one entry left", {7'd0, empty}, 0);
    @(negedge clk);
    chk("R9", "empty at flush end", {7'd0, empty}, 1);
    chk("R9", "not_full at flush end", {7'd0, not_full}, 1);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    chk("R9", "flush on empty", {7'd0, not_full & empty}, 1);
  endtask

  initial begin
    #12 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count_zero();
    t_clear();
    t_count_n();
    t_count_short();
    t_full();
    t_flush();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule